// File: doc/BRIEF.md
# Serial Frame Transmitter with Optional CRC-32

This block turns one frame into a serial bit stream. A start request in idle latches a 16-bit payload length and a CRC-inhibit control. The block then emits a fixed 56-bit alternating preamble and an 8-bit sync byte. After that it sends the payload bytes, which it draws from a byte source with a valid/ready handshake. All bytes go out least significant bit first, and one bit is consumed for every cycle in which the bit enable is high.

When the CRC is enabled, the block computes a CRC-32 over the payload bits as they leave. It then sends the complemented remainder as 32 further bits. When the CRC is inhibited, the stream stops after the last bit of the final payload byte, so software can place its own check value at the tail of the payload.

A down-counter starts at the payload length and drops by one for every byte the source hands over. A one-byte prefetch buffer fills during the preamble and stays one byte ahead of the serializer. If a payload byte is still missing at a byte boundary, the serializer holds that boundary and does not consume bits. At the end of the frame, a single-cycle done pulse fires and a sent flag is set. The flag stays set until the next accepted start.

Top module: `frame_tx_serializer`

## Requirements
- R1: While reset is applied and after its release, the block is idle: `tx_active_o`, `tx_bit_o`, `src_ready_o`, `done_o` and `sent_flag_o` are 0 and `tx_count_o` is 0.
- R2: A `start_i` pulse in idle makes `tx_active_o` 1 on the next cycle, loads `tx_count_o` with `byte_count_i` and clears `sent_flag_o`.
- R3: The first 56 serial bits of a frame alternate, starting with 1 (seven bytes of 0x55, LSB first). A bit is consumed only on a cycle with `bit_en_i` high, and `tx_bit_o` shows that bit before the edge.
- R4: The next 8 bits are the sync byte 0xD5 sent LSB first, which is the bit order 1,0,1,0,1,0,1,1.
- R5: The payload bytes follow the sync byte. Each byte is sent LSB first, and the bytes go out in the order the source delivered them.
- R6: `tx_count_o` decreases by exactly one on each cycle where `src_valid_i` and `src_ready_o` are both high. `src_ready_o` is never high while the count is 0.
- R7: With `crc_inhibit_i` = 0 at start, 32 bits follow the payload. They are the complement of a CRC-32 (reflected polynomial 0xEDB88320, register preset to all ones) taken over the payload bits in send order, and they go out LSB first. For the ASCII payload "123456789" these bits form the value 0xCBF43926.
- R8: With `crc_inhibit_i` = 1 at start, the frame is exactly 64 + 8·N bits long. Its last bit is bit 7 of the final payload byte.
- R9: In the cycle after the edge that consumes the last bit, `done_o` is high for exactly one cycle, `tx_active_o` is 0 and `sent_flag_o` is 1. `sent_flag_o` stays 1 until the next accepted start, and `tx_bit_o` is 0 whenever the block is idle.
- R10: A `start_i` pulse while `tx_active_o` is 1 has no effect. This includes a pulse in the cycle that consumes the final bit: the count and the bit stream are unchanged and the block still goes idle.
- R11: A zero-length frame sends only the preamble and the sync byte, followed by the CRC bits when the CRC is enabled. For an empty payload those CRC bits form 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (used only in idle) |
| crc_inhibit_i | input | 1 | 1 = send no CRC; latched at start |
| byte_count_i | input | 16 | Payload length in bytes; latched at start |
| bit_en_i | input | 1 | Serial bit strobe, one bit per high cycle |
| src_data_i | input | 8 | Payload byte from the source |
| src_valid_i | input | 1 | Source byte is valid |
| src_ready_o | output | 1 | Block accepts a source byte |
| tx_bit_o | output | 1 | Serial output bit |
| tx_active_o | output | 1 | Frame in progress |
| tx_count_o | output | 16 | Payload bytes still to be fetched |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| sent_flag_o | output | 1 | Frame sent; cleared on next start |

## Verification
Two events can fall in the same cycle: the consumption of the final serial bit and a new `start_i` request. The bench drives `start_i` on exactly the edge whose bit-enable consumes the last expected bit. It then checks that the block still goes idle with a done pulse, that the count stays at 0 and that no new frame begins. A second pulse in mid-frame is judged the same way against the bench's own fetch count. Payloads, bit-enable gaps and source-valid gaps are random. The received bit stream is compared with a stream the bench builds from preamble, sync, payload and its own CRC function, and the CRC function is anchored to the known check value of "123456789".

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_DATA,
    ST_FCS
  } ftx_state_e;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SYNC_BYTE     = 8'hD5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
endpackage

// File: rtl/ftx_crc32.sv
module ftx_crc32 #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = ftx_pkg::CRC_POLY_REFL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic fcs_bit_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] poly_w;

  assign poly_w = POLY[CRC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '1;
    end else if (init_i) begin
      crc_q <= '1;
    end else if (upd_i) begin
      crc_q <= {1'b0, crc_q[CRC_W-1:1]} ^ ((crc_q[0] ^ bit_i) ? poly_w : '0);
    end else if (shift_i) begin
      crc_q <= {1'b1, crc_q[CRC_W-1:1]};
    end
  end

  // remainder is sent inverted
  assign fcs_bit_o = ~crc_q[0];

  p_one_op_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && shift_i));
endmodule

// File: rtl/ftx_byte_counter.sv
module ftx_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
  p_dec_by_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/frame_tx_serializer.sv
module frame_tx_serializer #(
  parameter int CNT_W     = 16,
  parameter int PRE_BYTES = 7,
  parameter int CRC_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             crc_inhibit_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             bit_en_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  output logic             tx_bit_o,
  output logic             tx_active_o,
  output logic [CNT_W-1:0] tx_count_o,
  output logic             done_o,
  output logic             sent_flag_o
);
  import ftx_pkg::*;

  localparam int FCS_BYTES = CRC_W / 8;
  localparam int IDX_MAX   = (PRE_BYTES > FCS_BYTES) ? PRE_BYTES : FCS_BYTES;
  localparam int IDX_W     = $clog2(IDX_MAX) + 1;
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_BYTES - 1);
  localparam logic [IDX_W-1:0] FCS_LAST = IDX_W'(FCS_BYTES - 1);

  ftx_state_e       state_q;
  logic [7:0]       sh_q;
  logic [2:0]       bcnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       buf_q;
  logic             buf_vld_q;
  logic             inh_q;
  logic             done_q;
  logic             flag_q;

  logic active, start_ok, fetch, cnt_zero, byte_end, pay_edge, stall, step;
  logic fcs_bit;
  logic [CNT_W-1:0] cnt;

  assign active      = (state_q != ST_IDLE);
  assign start_ok    = start_i && !active;
  assign src_ready_o = active && !buf_vld_q && !cnt_zero;
  assign fetch       = src_ready_o && src_valid_i;
  assign byte_end    = (bcnt_q == 3'd7);
  assign pay_edge    = byte_end && ((state_q == ST_SYNC) || (state_q == ST_DATA));
  // hold a byte boundary while the next payload byte is outstanding
  assign stall       = pay_edge && !buf_vld_q && !cnt_zero;
  assign step        = bit_en_i && active && !stall;

  ftx_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_ok),
    .load_val_i (byte_count_i),
    .dec_i      (fetch),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  ftx_crc32 #(.CRC_W(CRC_W)) u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (start_ok),
    .upd_i     (step && (state_q == ST_DATA)),
    .bit_i     (sh_q[0]),
    .shift_i   (step && (state_q == ST_FCS)),
    .fcs_bit_o (fcs_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      bcnt_q    <= '0;
      idx_q     <= '0;
      buf_q     <= '0;
      buf_vld_q <= 1'b0;
      inh_q     <= 1'b0;
      done_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fetch) begin
        buf_q     <= src_data_i;
        buf_vld_q <= 1'b1;
      end
      if (start_ok) begin
        state_q   <= ST_PRE;
        sh_q      <= PRE_BYTE;
        bcnt_q    <= '0;
        idx_q     <= '0;
        buf_vld_q <= 1'b0;
        inh_q     <= crc_inhibit_i;
        flag_q    <= 1'b0;
      end else if (step) begin
        bcnt_q <= bcnt_q + 3'd1;
        sh_q   <= {1'b0, sh_q[7:1]};
        if (byte_end) begin
          unique case (state_q)
            ST_PRE: begin
              if (idx_q == PRE_LAST) begin
                state_q <= ST_SYNC;
                sh_q    <= SYNC_BYTE;
                idx_q   <= '0;
              end else begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= PRE_BYTE;
              end
            end
            ST_SYNC, ST_DATA: begin
              if (buf_vld_q) begin
                state_q   <= ST_DATA;
                sh_q      <= buf_q;
                buf_vld_q <= 1'b0;
              end else if (inh_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                flag_q  <= 1'b1;
              end else begin
                state_q <= ST_FCS;
                idx_q   <= '0;
              end
            end
            ST_FCS: begin
              if (idx_q == FCS_LAST) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                flag_q  <= 1'b1;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign tx_bit_o    = (state_q == ST_FCS) ? fcs_bit : (active & sh_q[0]);
  assign tx_active_o = active;
  assign tx_count_o  = cnt;
  assign done_o      = done_q;
  assign sent_flag_o = flag_q;

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> !tx_bit_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sent_flag_o && !tx_active_o));
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_o && start_i && !fetch) |=> $stable(tx_count_o));
  p_ready_needs_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> (tx_count_o != '0));
  p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> (tx_active_o && !sent_flag_o && tx_count_o == $past(byte_count_i)));
endmodule

// File: tb/frame_tx_serializer_test.sv
module frame_tx_serializer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        crc_inhibit_i = 1'b0;
  logic [15:0] byte_count_i = '0;
  logic        bit_en_i = 1'b0;
  logic [7:0]  src_data_i = '0;
  logic        src_valid_i = 1'b0;
  logic        src_ready_o, tx_bit_o, tx_active_o, done_o, sent_flag_o;
  logic [15:0] tx_count_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] pay [0:63];
  logic       exp_bits [0:1023];
  logic       got_bits [0:1023];
  int         exp_n;

  frame_tx_serializer uut (
    .clk_i, .rst_ni, .start_i, .crc_inhibit_i, .byte_count_i, .bit_en_i,
    .src_data_i, .src_valid_i, .src_ready_o, .tx_bit_o, .tx_active_o,
    .tx_count_o, .done_o, .sent_flag_o
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ pay[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic build_expected(input int len, input bit inh);
    logic [31:0] fcs;
    exp_n = 0;
    for (int i = 0; i < 56; i++) begin exp_bits[exp_n] = ~i[0]; exp_n++; end
    for (int b = 0; b < 8; b++) begin exp_bits[exp_n] = 8'hD5 >> b; exp_n++; end
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin exp_bits[exp_n] = pay[i][b]; exp_n++; end
    if (!inh) begin
      fcs = crc_of(len);
      for (int b = 0; b < 32; b++) begin exp_bits[exp_n] = fcs[b]; exp_n++; end
    end
  endtask

  task automatic run_frame(input int len, input bit inh, input bit poke_last, input bit poke_mid);
    int rec = 0;
    int fetched = 0;
    int cnt_bad = 0;
    int inval_run = 0;
    int guard = 0;
    int bad_pre = 0, bad_sync = 0, bad_rest = 0;
    logic [15:0] bad_cnt_val = '0;
    logic [31:0] tail;
    bit be, sv;
    build_expected(len, inh);
    @(negedge clk_i);
    start_i = 1'b1; byte_count_i = 16'(len); crc_inhibit_i = inh;
    bit_en_i = 1'b0; src_valid_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(tx_active_o && !sent_flag_o && tx_count_o == 16'(len), "R2 start loads",
        {tx_active_o, sent_flag_o, tx_count_o}, {2'b10, 16'(len)});
    while (rec < exp_n && guard < 20000) begin
      guard++;
      if (tx_count_o != 16'(len - fetched)) begin cnt_bad++; bad_cnt_val = tx_count_o; end
      be = ($urandom % 4) != 0;
      sv = (inval_run >= 2) ? 1'b1 : (($urandom % 4) != 0);
      inval_run = sv ? 0 : inval_run + 1;
      bit_en_i = be;
      src_valid_i = sv;
      src_data_i = (fetched < len) ? pay[fetched] : 8'h00;
      if (src_ready_o && sv) fetched++;
      if (be && tx_active_o) begin got_bits[rec] = tx_bit_o; rec++; end
      start_i = 1'b0;
      if (poke_mid && rec == 20) begin start_i = 1'b1; byte_count_i = 16'h00FF; end
      if (poke_last && be && rec == exp_n) begin start_i = 1'b1; byte_count_i = 16'h0033; end
      @(negedge clk_i);
    end
    start_i = 1'b0; bit_en_i = 1'b0; src_valid_i = 1'b0;
    chk(cnt_bad == 0 && fetched == len, "R6 count tracks fetches", bad_cnt_val, 16'(len - fetched));
    for (int i = 0; i < exp_n; i++) begin
      if (got_bits[i] !== exp_bits[i]) begin
        if (i < 56) bad_pre++; else if (i < 64) bad_sync++; else bad_rest++;
      end
    end
    chk(bad_pre == 0, "R3 preamble bits", bad_pre, 0);
    chk(bad_sync == 0, "R4 sync bits", bad_sync, 0);
    if (inh) chk(bad_rest == 0, "R5 R8 payload bits, no CRC", bad_rest, 0);
    else     chk(bad_rest == 0, "R5 R7 payload and CRC bits", bad_rest, 0);
    if (inh && len > 0)
      chk(got_bits[exp_n-1] == pay[len-1][7], "R8 last bit from final byte",
          got_bits[exp_n-1], pay[len-1][7]);
    if (!inh) begin
      for (int b = 0; b < 32; b++) tail[b] = got_bits[exp_n-32+b];
      if (len == 0) chk(tail == 32'h0, "R11 empty-frame CRC", tail, 32'h0);
    end
    chk(done_o && sent_flag_o && !tx_active_o && tx_count_o == 16'h0,
        poke_last ? "R9 R10 done and start at final bit ignored" : "R9 done pulse",
        {done_o, sent_flag_o, tx_active_o, tx_count_o}, {3'b110, 16'h0});
    @(negedge clk_i);
    chk(!done_o && sent_flag_o && !tx_active_o && !tx_bit_o && !src_ready_o,
        "R9 idle after done", {done_o, sent_flag_o, tx_active_o, tx_bit_o, src_ready_o}, 5'b01000);
  endtask

  initial begin
    logic [31:0] tail;
    repeat (3) @(negedge clk_i);
    chk(!tx_active_o && !tx_bit_o && !src_ready_o && !done_o && !sent_flag_o && tx_count_o == 0,
        "R1 reset state", {tx_active_o, tx_bit_o, src_ready_o, done_o, sent_flag_o, tx_count_o},
        21'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!tx_active_o && tx_count_o == 0, "R1 idle after release", {tx_active_o, tx_count_o}, 17'h0);

    void'($urandom(32'd4711));
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    run_frame(9, 1'b0, 1'b0, 1'b0);
    for (int b = 0; b < 32; b++) tail[b] = got_bits[exp_n-32+b];
    chk(tail == 32'hCBF43926, "R7 check value 123456789", tail, 32'hCBF43926);

    run_frame(0, 1'b0, 1'b0, 1'b0);
    run_frame(0, 1'b1, 1'b0, 1'b0);
    pay[0] = 8'h80;
    run_frame(1, 1'b1, 1'b1, 1'b0);
    pay[0] = 8'hA5; pay[1] = 8'h3C;
    run_frame(2, 1'b0, 1'b1, 1'b1);

    for (int f = 0; f < 10; f++) begin
      int len = 1 + int'($urandom % 40);
      for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
      run_frame(len, 1'($urandom % 2), 1'(f % 3 == 0), 1'(f % 2 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule